// File: doc/BRIEF.md
# Multi-Data FIFO Holding Register Port

This block sits between a 32-bit register bus and the transmit and receive character FIFOs of a serial port. A bus read of the receive holding register pops characters from the RX FIFO. A bus write of the transmit holding register pushes characters into the TX FIFO. The number of characters moved depends on the access size and on the port's data mode. A byte access always moves one character. A word access moves four packed characters when the port is in multiple-data mode, and one character when it is in single-data mode. The mode is derived from the 9-bit-data bit and the protocol mode field.

The FIFO-side interface is a count-qualified stream. Each cycle the adapter states how many characters the FIFO must pop or push, from zero to four, and presents the packed lanes. It never asks for more characters than the reported level holds, or more than the free space allows, so the FIFO never has to apply back-pressure. A word access that cannot be fully served is truncated, and the matching pointer-error pulse is raised. The block also produces TX-ready and RX-ready levels from two programmable ready-mode fields. Read data is returned one cycle after the access, together with a valid pulse.

Top module: `hrp_fifo_port`

## Requirements
- R1: The port is in single-data mode when `mode9` is 1, or when `proto_mode` is 4'h9, 4'hA or 4'hB. In every other case it is in multiple-data mode.
- R2: A byte access (`bus_word`=0) moves exactly one character through byte lane 0 (bits 7:0), in either mode.
- R3: In single-data mode, a word access moves exactly one character, through lane 0.
- R4: In multiple-data mode, a word read of the RHR address pops four characters. Head character n lands in bits 8n+7:8n. `bus_rdata` and a one-cycle `bus_rvalid` appear in the cycle after the access.
- R5: In multiple-data mode, a word write of the THR address pushes four characters in the same cycle. Lane 0 (bits 7:0) is the first character.
- R6: When a multiple-data word read finds fewer than four characters, only the stored characters are popped. Unfilled lanes of `bus_rdata` read 0, and `rx_ptr_err` pulses in the next cycle.
- R7: When a multiple-data word write finds fewer than four free slots, only as many characters as fit are pushed, and `tx_ptr_err` pulses in the next cycle. Free space is DEPTH (32) minus the TX level.
- R8: `rx_ready` is 1 when the RX level (`fifo_level` bits 21:16) is at least N. N comes from `fifo_mode` bits 5:4: 0 gives 1, 1 gives 2, 2 gives 4, and 3 gives 1.
- R9: `tx_ready` is 1 when the free TX space (DEPTH minus `fifo_level` bits 5:0) is at least N. N comes from `fifo_mode` bits 1:0, with the same encoding as R8.
- R10: Only reads at RHR_ADDR (8'h18) and writes at THR_ADDR (8'h1C) move characters. Any other access, or a byte read of an empty RX FIFO, moves nothing and raises no error.
- R11: After reset, `bus_rdata` is 0, and `bus_rvalid`, `tx_ptr_err` and `rx_ptr_err` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| bus_valid | input | 1 | Bus access this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 8 | Register address |
| bus_word | input | 1 | 1 = 32-bit access, 0 = byte access |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, registered |
| bus_rvalid | output | 1 | Read data valid pulse |
| mode9 | input | 1 | 9-bit character mode |
| proto_mode | input | 4 | Protocol mode field |
| fifo_mode | input | 32 | Ready-mode word (TX 1:0, RX 5:4) |
| fifo_level | input | 32 | Level word (TX 5:0, RX 21:16) |
| tx_push_cnt | output | 3 | Characters to push this cycle |
| tx_push_data | output | 32 | Packed push lanes |
| rx_pop_cnt | output | 3 | Characters to pop this cycle |
| rx_head_data | input | 32 | Next four RX characters, oldest in lane 0 |
| tx_ptr_err | output | 1 | Short multi-data write pulse |
| rx_ptr_err | output | 1 | Short multi-data read pulse |
| tx_ready | output | 1 | TX space meets the ready mode |
| rx_ready | output | 1 | RX level meets the ready mode |

## Verification
On every cycle, the assertions check four properties. The push count never exceeds the free TX space, and the pop count never exceeds the RX level. Single-data mode and byte accesses never move more than one character. Idle cycles and stray addresses move nothing. Read-valid and RX error pulses only follow a qualifying access. Lane ordering, the truncated data pattern of a short access, the exact ready thresholds of each encoding, and the full mode-decode table can only be shown by the bench's directed scenarios, which compare data values.

// File: rtl/hrp_pkg.sv
package hrp_pkg;
  localparam logic [3:0] PM_LON    = 4'h9;
  localparam logic [3:0] PM_LIN_M  = 4'hA;
  localparam logic [3:0] PM_LIN_S  = 4'hB;

  typedef enum logic [1:0] {
    RDY_ONE  = 2'd0,
    RDY_TWO  = 2'd1,
    RDY_FOUR = 2'd2,
    RDY_RSVD = 2'd3
  } rdy_mode_e;

  function automatic logic [2:0] rdy_need(input rdy_mode_e m);
    case (m)
      RDY_TWO:  return 3'd2;
      RDY_FOUR: return 3'd4;
      default:  return 3'd1;
    endcase
  endfunction
endpackage

// File: rtl/hrp_mode_dec.sv
module hrp_mode_dec
  import hrp_pkg::*;
(
  input  logic       mode9,
  input  logic [3:0] proto_mode,
  output logic       multi
);
  logic proto_single;
  always_comb begin
    proto_single = (proto_mode == PM_LON) || (proto_mode == PM_LIN_M) ||
                   (proto_mode == PM_LIN_S);
    multi = !(mode9 || proto_single);
  end
endmodule

// File: rtl/hrp_lane_sel.sv
module hrp_lane_sel #(
  parameter int LANES = 4,
  parameter int DW    = 8,
  parameter int AW    = 7,
  localparam int CNT_W = $clog2(LANES + 1),
  localparam int BW    = LANES * DW
) (
  input  logic            want_all,
  input  logic [AW-1:0]   avail,
  input  logic [BW-1:0]   data_in,
  output logic [CNT_W-1:0] cnt,
  output logic [BW-1:0]   data_out,
  output logic            short_acc
);
  logic [AW-1:0] want;
  always_comb begin
    want      = want_all ? AW'(LANES) : AW'(1);
    cnt       = (avail < want) ? CNT_W'(avail) : CNT_W'(want);
    short_acc = want_all && (avail < AW'(LANES));
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign data_out[g*DW +: DW] = (CNT_W'(g) < cnt) ? data_in[g*DW +: DW] : '0;
  end
endmodule

// File: rtl/hrp_ready.sv
module hrp_ready
  import hrp_pkg::*;
#(
  parameter int AW = 7
) (
  input  logic [AW-1:0] amount,
  input  logic [1:0]    mode,
  output logic          rdy
);
  assign rdy = amount >= AW'(rdy_need(rdy_mode_e'(mode)));
endmodule

// File: rtl/hrp_fifo_port.sv
module hrp_fifo_port #(
  parameter int          LANES    = 4,
  parameter int          DW       = 8,
  parameter int          LVL_W    = 6,
  parameter int          DEPTH    = 32,
  parameter logic [7:0]  RHR_ADDR = 8'h18,
  parameter logic [7:0]  THR_ADDR = 8'h1C,
  localparam int         CNT_W    = $clog2(LANES + 1),
  localparam int         BW       = LANES * DW,
  localparam int         AW       = LVL_W + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus_valid,
  input  logic             bus_we,
  input  logic [7:0]       bus_addr,
  input  logic             bus_word,
  input  logic [BW-1:0]    bus_wdata,
  output logic [BW-1:0]    bus_rdata,
  output logic             bus_rvalid,
  input  logic             mode9,
  input  logic [3:0]       proto_mode,
  input  logic [31:0]      fifo_mode,
  input  logic [31:0]      fifo_level,
  output logic [CNT_W-1:0] tx_push_cnt,
  output logic [BW-1:0]    tx_push_data,
  output logic [CNT_W-1:0] rx_pop_cnt,
  input  logic [BW-1:0]    rx_head_data,
  output logic             tx_ptr_err,
  output logic             rx_ptr_err,
  output logic             tx_ready,
  output logic             rx_ready
);
  logic          multi, rd_hit, wr_hit, want_all;
  logic [AW-1:0] rx_lvl, tx_lvl, tx_free;
  logic [CNT_W-1:0] rx_cnt, tx_cnt;
  logic [BW-1:0] rx_lanes, tx_lanes;
  logic          rx_short, tx_short;

  hrp_mode_dec u_mode (.mode9(mode9), .proto_mode(proto_mode), .multi(multi));

  always_comb begin
    rd_hit   = bus_valid && !bus_we && (bus_addr == RHR_ADDR);
    wr_hit   = bus_valid &&  bus_we && (bus_addr == THR_ADDR);
    want_all = bus_word && multi;
    rx_lvl   = {1'b0, fifo_level[16 +: LVL_W]};
    tx_lvl   = {1'b0, fifo_level[0 +: LVL_W]};
    tx_free  = (tx_lvl >= AW'(DEPTH)) ? '0 : AW'(DEPTH) - tx_lvl;
  end

  hrp_lane_sel #(.LANES(LANES), .DW(DW), .AW(AW)) u_rx_sel (
    .want_all(want_all), .avail(rx_lvl), .data_in(rx_head_data),
    .cnt(rx_cnt), .data_out(rx_lanes), .short_acc(rx_short));

  hrp_lane_sel #(.LANES(LANES), .DW(DW), .AW(AW)) u_tx_sel (
    .want_all(want_all), .avail(tx_free), .data_in(bus_wdata),
    .cnt(tx_cnt), .data_out(tx_lanes), .short_acc(tx_short));

  hrp_ready #(.AW(AW)) u_rx_rdy (.amount(rx_lvl),  .mode(fifo_mode[5:4]), .rdy(rx_ready));
  hrp_ready #(.AW(AW)) u_tx_rdy (.amount(tx_free), .mode(fifo_mode[1:0]), .rdy(tx_ready));

  always_comb begin
    rx_pop_cnt   = rd_hit ? rx_cnt   : '0;
    tx_push_cnt  = wr_hit ? tx_cnt   : '0;
    tx_push_data = wr_hit ? tx_lanes : '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_rdata  <= '0;
      bus_rvalid <= 1'b0;
      rx_ptr_err <= 1'b0;
      tx_ptr_err <= 1'b0;
    end else begin
      bus_rvalid <= rd_hit;
      rx_ptr_err <= rd_hit && rx_short;
      tx_ptr_err <= wr_hit && tx_short;
      if (rd_hit) bus_rdata <= rx_lanes;
    end
  end
endmodule

// File: rtl/hrp_fifo_port_chk.sv
module hrp_fifo_port_chk #(
  parameter int          LANES    = 4,
  parameter int          DW       = 8,
  parameter int          LVL_W    = 6,
  parameter int          DEPTH    = 32,
  parameter logic [7:0]  RHR_ADDR = 8'h18,
  parameter logic [7:0]  THR_ADDR = 8'h1C,
  localparam int         CNT_W    = $clog2(LANES + 1),
  localparam int         BW       = LANES * DW
) (
  input logic             clk,
  input logic             rst_n,
  input logic             bus_valid,
  input logic             bus_we,
  input logic [7:0]       bus_addr,
  input logic             bus_word,
  input logic [BW-1:0]    bus_wdata,
  input logic [BW-1:0]    bus_rdata,
  input logic             bus_rvalid,
  input logic             mode9,
  input logic [3:0]       proto_mode,
  input logic [31:0]      fifo_mode,
  input logic [31:0]      fifo_level,
  input logic [CNT_W-1:0] tx_push_cnt,
  input logic [BW-1:0]    tx_push_data,
  input logic [CNT_W-1:0] rx_pop_cnt,
  input logic [BW-1:0]    rx_head_data,
  input logic             tx_ptr_err,
  input logic             rx_ptr_err,
  input logic             tx_ready,
  input logic             rx_ready
);
  logic single_md;
  int   tx_room;
  assign single_md = mode9 || (proto_mode inside {4'h9, 4'hA, 4'hB});
  assign tx_room   = DEPTH - int'(fifo_level[0 +: LVL_W]);

  // R7
  tx_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(tx_push_cnt) <= ((tx_room < 0) ? 0 : tx_room));

  // R6
  rx_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    int'(rx_pop_cnt) <= int'(fifo_level[16 +: LVL_W]));

  // R3
  single_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    single_md |-> (rx_pop_cnt <= 1 && tx_push_cnt <= 1));

  // R2
  byte_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_valid && !bus_word) |-> (rx_pop_cnt <= 1 && tx_push_cnt <= 1));

  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_valid || (bus_addr != RHR_ADDR && bus_addr != THR_ADDR)) |->
      (rx_pop_cnt == 0 && tx_push_cnt == 0));

  // R4
  rvalid_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rvalid |-> $past(bus_valid && !bus_we && bus_addr == RHR_ADDR));

  // R6
  rx_err_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_ptr_err |-> $past(int'(rx_pop_cnt) < LANES && bus_word));
endmodule

bind hrp_fifo_port hrp_fifo_port_chk #(
  .LANES(LANES), .DW(DW), .LVL_W(LVL_W), .DEPTH(DEPTH),
  .RHR_ADDR(RHR_ADDR), .THR_ADDR(THR_ADDR)
) u_chk (.*);

// File: tb/hrp_fifo_port_tb.sv
module hrp_fifo_port_tb;
  logic        clk = 0, rst_n = 0;
  logic        bus_valid = 0, bus_we = 0, bus_word = 0;
  logic [7:0]  bus_addr = 0;
  logic [31:0] bus_wdata = 0, bus_rdata, fifo_mode = 0, fifo_level = 0, tx_push_data;
  logic [31:0] rx_head_data = 32'hD4C3B2A1;
  logic        bus_rvalid, mode9 = 0, tx_ptr_err, rx_ptr_err, tx_ready, rx_ready;
  logic [3:0]  proto_mode = 0;
  logic [2:0]  tx_push_cnt, rx_pop_cnt;
  int total = 0, fails = 0;
  bit done = 0;
  logic [31:0] s_cnt, s_data;

  localparam logic [7:0] RHR = 8'h18, THR = 8'h1C;

  always #10 clk = ~clk;

  hrp_fifo_port u_dut (.*);

  task automatic chk(string tag, logic [31:0] got, logic [31:0] exp);
    total++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [31:0] lvl(int rx, int tx);
    return {10'b0, 6'(rx), 10'b0, 6'(tx)};
  endfunction

  // drive at negedge, sample comb outputs, pass one posedge, release
  task automatic access(logic we, logic [7:0] a, logic word, logic [31:0] wd);
    @(negedge clk);
    bus_valid = 1; bus_we = we; bus_addr = a; bus_word = word; bus_wdata = wd;
    #2;
    s_cnt  = we ? 32'(tx_push_cnt) : 32'(rx_pop_cnt);
    s_data = tx_push_data;
    @(negedge clk);
    bus_valid = 0;
  endtask

  task automatic t_reset;
    chk("R11 rdata", bus_rdata, 0);
    chk("R11 rvalid", 32'(bus_rvalid), 0);
    chk("R11 errs", {30'b0, tx_ptr_err, rx_ptr_err}, 0);
  endtask

  task automatic t_mode_dec;
    logic [3:0] codes [4] = '{4'h0, 4'h9, 4'hA, 4'hB};
    int exp [4] = '{4, 1, 1, 1};
    fifo_level = lvl(8, 0);
    for (int i = 0; i < 4; i++) begin
      proto_mode = codes[i];
      access(0, RHR, 1, 0);
      chk($sformatf("R1 proto %h", codes[i]), s_cnt, exp[i]);
    end
    proto_mode = 4'h0; mode9 = 1;
    access(0, RHR, 1, 0);
    chk("R1 mode9", s_cnt, 1);
    mode9 = 0; proto_mode = 4'h2;
    access(0, RHR, 1, 0);
    chk("R1 other proto", s_cnt, 4);
    proto_mode = 0;
  endtask

  task automatic t_byte;
    fifo_level = lvl(8, 0);
    access(0, RHR, 0, 0);
    chk("R2 byte pop", s_cnt, 1);
    chk("R2 byte rdata", bus_rdata, 32'h000000A1);
    access(1, THR, 0, 32'h11223344);
    chk("R2 byte push", s_cnt, 1);
    chk("R2 byte lane", s_data, 32'h00000044);
  endtask

  task automatic t_single_word;
    mode9 = 1; fifo_level = lvl(8, 0);
    access(1, THR, 1, 32'h11223344);
    chk("R3 push cnt", s_cnt, 1);
    chk("R3 push data", s_data, 32'h00000044);
    access(0, RHR, 1, 0);
    chk("R3 rdata", bus_rdata, 32'h000000A1);
    mode9 = 0;
  endtask

  task automatic t_multi_read;
    fifo_level = lvl(8, 0);
    access(0, RHR, 1, 0);
    chk("R4 pop cnt", s_cnt, 4);
    chk("R4 rdata", bus_rdata, 32'hD4C3B2A1);
    chk("R4 rvalid", 32'(bus_rvalid), 1);
    chk("R4 no err", 32'(rx_ptr_err), 0);
    @(negedge clk);
    chk("R4 rvalid pulse", 32'(bus_rvalid), 0);
  endtask

  task automatic t_multi_write;
    fifo_level = lvl(0, 10);
    access(1, THR, 1, 32'h11223344);
    chk("R5 push cnt", s_cnt, 4);
    chk("R5 push data", s_data, 32'h11223344);
    chk("R5 no err", 32'(tx_ptr_err), 0);
  endtask

  task automatic t_short_read;
    fifo_level = lvl(2, 0);
    access(0, RHR, 1, 0);
    chk("R6 pop cnt", s_cnt, 2);
    chk("R6 rdata", bus_rdata, 32'h0000B2A1);
    chk("R6 err", 32'(rx_ptr_err), 1);
    @(negedge clk);
    chk("R6 err pulse", 32'(rx_ptr_err), 0);
  endtask

  task automatic t_short_write;
    fifo_level = lvl(0, 30);
    access(1, THR, 1, 32'h11223344);
    chk("R7 push cnt", s_cnt, 2);
    chk("R7 push data", s_data, 32'h00003344);
    chk("R7 err", 32'(tx_ptr_err), 1);
    fifo_level = lvl(0, 32);
    access(1, THR, 1, 32'h11223344);
    chk("R7 full cnt", s_cnt, 0);
    chk("R7 full err", 32'(tx_ptr_err), 1);
  endtask

  task automatic t_ready;
    @(negedge clk);
    fifo_mode = 32'h10; fifo_level = lvl(1, 0); #1;
    chk("R8 two lvl1", 32'(rx_ready), 0);
    fifo_level = lvl(2, 0); #1;
    chk("R8 two lvl2", 32'(rx_ready), 1);
    fifo_mode = 32'h20; fifo_level = lvl(3, 0); #1;
    chk("R8 four lvl3", 32'(rx_ready), 0);
    fifo_level = lvl(4, 0); #1;
    chk("R8 four lvl4", 32'(rx_ready), 1);
    fifo_mode = 32'h00; fifo_level = lvl(0, 0); #1;
    chk("R8 one lvl0", 32'(rx_ready), 0);
    fifo_mode = 32'h02; fifo_level = lvl(0, 28); #1;
    chk("R9 four free4", 32'(tx_ready), 1);
    fifo_level = lvl(0, 29); #1;
    chk("R9 four free3", 32'(tx_ready), 0);
    fifo_mode = 32'h01; fifo_level = lvl(0, 31); #1;
    chk("R9 two free1", 32'(tx_ready), 0);
    fifo_mode = 32'h03; #1;
    chk("R9 rsvd free1", 32'(tx_ready), 1);
    fifo_mode = 0;
  endtask

  task automatic t_ignore;
    fifo_level = lvl(8, 0);
    access(0, THR, 1, 0);
    chk("R10 read thr cnt", s_cnt, 0);
    chk("R10 read thr rvalid", 32'(bus_rvalid), 0);
    access(1, RHR, 1, 32'hFFFFFFFF);
    chk("R10 write rhr cnt", s_cnt, 0);
    chk("R10 write rhr data", s_data, 0);
    fifo_level = lvl(0, 0);
    access(0, RHR, 0, 0);
    chk("R10 empty byte cnt", s_cnt, 0);
    chk("R10 empty byte rdata", bus_rdata, 0);
    chk("R10 empty byte err", 32'(rx_ptr_err), 0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1;
    t_mode_dec;
    t_byte;
    t_single_word;
    t_multi_read;
    t_multi_write;
    t_short_read;
    t_short_write;
    t_ready;
    t_ignore;
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule